// File: doc/BRIEF.md
# Snooping Write-Back Data Cache

A direct-mapped, write-back data cache placed between a CPU load/store port and a word-wide lower-level memory port. A separate DMA port reaches the same address space, and every DMA access is checked against the cache (snooped). A DMA read that finds the line present takes its data from the cache. A DMA write that finds the line present updates the cached word and memory, so the two copies agree. A DMA access that misses goes straight to memory and leaves the cache alone.

Software keeps buffers coherent through a maintenance port that acts on one line, chosen by memory address. There are three commands: write back, invalidate, and write back then invalidate. Every port uses a request/ready handshake. The requester holds its request until the block raises ready (or done) for one cycle. Memory transfers move one word per handshake, and a whole line is always filled or written back as four consecutive words, lowest offset first.

Addresses are word addresses. Bits [1:0] pick the word in a line, bits [5:2] pick the line, and the remaining upper bits form the tag.

Top module: `snoop_wb_cache`

## Requirements
- R1: After reset every line is invalid and no port shows ready or done. The first CPU read of any address therefore misses and fills from memory.
- R2: A CPU read or write that hits completes in the cycle of the request with no memory traffic. A write hit changes only the cache and marks the line dirty.
- R3: A CPU miss reads the new line from memory as four reads, offsets 0 to 3, and then completes. If the old line in that slot is dirty, four writes of the old line (offsets 0 to 3) come first.
- R4: A line is never dirty while invalid. After an invalidate, a writeback command on the same address causes no memory traffic.
- R5: When a DMA request arrives in the same cycle as a CPU request, the DMA access is served first. The CPU ready stays low until the DMA access has completed.
- R6: A DMA read that hits returns the cached word in the cycle of the request. No memory access takes place and memory is left unchanged.
- R7: A DMA write that hits updates the cached word and performs one memory write of the same word. The line's dirty state is unchanged, and DMA ready is raised on the memory acknowledge.
- R8: A DMA access that misses performs exactly one memory access at its address and changes no cache state.
- R9: Command op=2'b01 (write back) on a valid dirty line writes the four words to memory. The line then stays valid and clean.
- R10: Command op=2'b10 (invalidate) on a present line clears it with no memory traffic, discarding dirty data. The next CPU read of that line refills from memory.
- R11: Command op=2'b11 writes a dirty line back and then invalidates it. Done rises only in the cycle of the last write acknowledge.
- R12: A command on an absent line, or a write back of a clean line, raises done in the cycle of the request with no memory traffic.
- R13: While mem_req_o is high and mem_ready_i is low, address, direction and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | CPU request, held until ready |
| cpu_we_i | input | 1 | CPU write when high |
| cpu_addr_i | input | ADDR_W | CPU word address |
| cpu_wdata_i | input | DATA_W | CPU write data |
| cpu_ready_o | output | 1 | CPU access complete |
| cpu_rdata_o | output | DATA_W | CPU read data, valid with ready |
| dma_req_i | input | 1 | DMA request, held until ready |
| dma_we_i | input | 1 | DMA write when high |
| dma_addr_i | input | ADDR_W | DMA word address |
| dma_wdata_i | input | DATA_W | DMA write data |
| dma_ready_o | output | 1 | DMA access complete |
| dma_rdata_o | output | DATA_W | DMA read data, valid with ready |
| mnt_req_i | input | 1 | Maintenance request, held until done |
| mnt_op_i | input | 2 | Bit 0 write back, bit 1 invalidate |
| mnt_addr_i | input | ADDR_W | Address selecting the line |
| mnt_done_o | output | 1 | Maintenance command complete |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Memory write when high |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ready_i | input | 1 | Memory acknowledge, read data valid |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
A wrong tag, valid or dirty bit shows up at the ports at the next access to that line. A wrongly present line gives a hit with no memory traffic where the reference expects a fill. A wrongly lost dirty bit drops the four writeback words from an eviction or a command. A stale cached word comes back on the first CPU or DMA read of that address. The reference tracks the expected memory contents and the value each address should read, so a corrupted word is reported on the first read that returns it. The exact sequence of memory accesses is compared for each transaction.

// File: rtl/snoop_cache_pkg.sv
package snoop_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_DMA
  } cache_st_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic             lk_dirty_o,
  output logic [TAG_W-1:0] lk_tag_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_valid_i,
  input  logic             upd_dirty_i,
  input  logic [TAG_W-1:0] upd_tag_i
);
  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  assign lk_tag_o   = tag_q[lk_idx_i];
  assign lk_hit_o   = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  // victim dirty, independent of tag match
  assign lk_dirty_o = valid_q[lk_idx_i] && dirty_q[lk_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (upd_en_i) begin
      valid_q[upd_idx_i] <= upd_valid_i;
      dirty_q[upd_idx_i] <= upd_valid_i && upd_dirty_i;
      tag_q[upd_idx_i]   <= upd_tag_i;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line_chk
    a_r4_dirty_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dirty_q[g] |-> valid_q[g]);
  end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[rd_slot_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_slot_i] <= wr_data_i;
  end
endmodule

// File: rtl/snoop_wb_cache.sv
module snoop_wb_cache
  import snoop_cache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              dma_req_i,
  input  logic              dma_we_i,
  input  logic [ADDR_W-1:0] dma_addr_i,
  input  logic [DATA_W-1:0] dma_wdata_i,
  output logic              dma_ready_o,
  output logic [DATA_W-1:0] dma_rdata_o,
  input  logic              mnt_req_i,
  input  logic [1:0]        mnt_op_i,
  input  logic [ADDR_W-1:0] mnt_addr_i,
  output logic              mnt_done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int SLOT_W = IDX_W + OFF_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  cache_st_e         st_q;
  logic [OFF_W-1:0]  word_q;
  logic [LINE_W-1:0] wb_line_q, fill_line_q;
  logic              wb_mnt_q, mnt_inv_q, dma_we_q;
  logic [ADDR_W-1:0] dma_addr_q;
  logic [DATA_W-1:0] dma_wdata_q;

  logic              idle, g_dma, g_mnt, g_cpu;
  logic [ADDR_W-1:0] sel_addr;
  logic [IDX_W-1:0]  sel_idx;
  logic [TAG_W-1:0]  sel_tag;
  logic [OFF_W-1:0]  sel_off;
  logic              lk_hit, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic [SLOT_W-1:0] rd_slot;
  logic [DATA_W-1:0] rd_data;
  logic              cpu_hit, dma_hit, mnt_wb_go, wb_last, fill_last;
  logic              dw_en;
  logic [SLOT_W-1:0] dw_slot;
  logic [DATA_W-1:0] dw_data;
  logic              tu_en, tu_valid, tu_dirty;
  logic [IDX_W-1:0]  tu_idx;
  logic [TAG_W-1:0]  tu_tag;

  // snoop first, then maintenance, then CPU
  assign idle     = (st_q == ST_IDLE);
  assign g_dma    = dma_req_i;
  assign g_mnt    = !dma_req_i && mnt_req_i;
  assign g_cpu    = !dma_req_i && !mnt_req_i && cpu_req_i;
  assign sel_addr = g_dma ? dma_addr_i : (g_mnt ? mnt_addr_i : cpu_addr_i);
  assign sel_off  = sel_addr[OFF_W-1:0];
  assign sel_idx  = sel_addr[OFF_W +: IDX_W];
  assign sel_tag  = sel_addr[ADDR_W-1 -: TAG_W];
  assign rd_slot  = idle ? {sel_idx, sel_off} : {wb_line_q[IDX_W-1:0], word_q};

  assign cpu_hit   = idle && g_cpu && lk_hit;
  assign dma_hit   = idle && g_dma && lk_hit;
  assign mnt_wb_go = idle && g_mnt && mnt_op_i[0] && lk_hit && lk_dirty;
  assign wb_last   = (st_q == ST_WB) && mem_ready_i && (word_q == LAST_OFF);
  assign fill_last = (st_q == ST_FILL) && mem_ready_i && (word_q == LAST_OFF);

  cache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .lk_idx_i(sel_idx), .lk_tag_i(sel_tag),
    .lk_hit_o(lk_hit), .lk_dirty_o(lk_dirty), .lk_tag_o(lk_tag),
    .upd_en_i(tu_en), .upd_idx_i(tu_idx), .upd_valid_i(tu_valid),
    .upd_dirty_i(tu_dirty), .upd_tag_i(tu_tag)
  );

  cache_data_store #(.DEPTH(LINES * WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i,
    .rd_slot_i(rd_slot), .rd_data_o(rd_data),
    .wr_en_i(dw_en), .wr_slot_i(dw_slot), .wr_data_i(dw_data)
  );

  assign cpu_ready_o = cpu_hit;
  assign cpu_rdata_o = rd_data;
  assign dma_ready_o = (dma_hit && !dma_we_i) || ((st_q == ST_DMA) && mem_ready_i);
  assign dma_rdata_o = (st_q == ST_DMA) ? mem_rdata_i : rd_data;
  assign mnt_done_o  = (idle && g_mnt && !mnt_wb_go) || (wb_last && wb_mnt_q);
  assign mem_req_o   = !idle;
  assign mem_we_o    = (st_q == ST_WB) || ((st_q == ST_DMA) && dma_we_q);
  assign mem_wdata_o = (st_q == ST_DMA) ? dma_wdata_q : rd_data;

  always_comb begin
    unique case (st_q)
      ST_WB:   mem_addr_o = {wb_line_q, word_q};
      ST_FILL: mem_addr_o = {fill_line_q, word_q};
      default: mem_addr_o = dma_addr_q;
    endcase
  end

  always_comb begin
    dw_en   = 1'b0;
    dw_slot = {sel_idx, sel_off};
    dw_data = cpu_wdata_i;
    if (cpu_hit && cpu_we_i) begin
      dw_en = 1'b1;
    end else if (dma_hit && dma_we_i) begin
      dw_en   = 1'b1;
      dw_data = dma_wdata_i;
    end else if ((st_q == ST_FILL) && mem_ready_i) begin
      dw_en   = 1'b1;
      dw_slot = {fill_line_q[IDX_W-1:0], word_q};
      dw_data = mem_rdata_i;
    end
  end

  always_comb begin
    tu_en    = 1'b0;
    tu_idx   = sel_idx;
    tu_tag   = lk_tag;
    tu_valid = 1'b1;
    tu_dirty = 1'b0;
    if (cpu_hit && cpu_we_i) begin
      tu_en    = 1'b1;
      tu_dirty = 1'b1;
    end else if (idle && g_mnt && mnt_op_i[1] && lk_hit && !mnt_wb_go) begin
      tu_en    = 1'b1;
      tu_valid = 1'b0;
    end else if (wb_last && wb_mnt_q) begin
      tu_en    = 1'b1;
      tu_idx   = wb_line_q[IDX_W-1:0];
      tu_tag   = wb_line_q[LINE_W-1:IDX_W];
      tu_valid = !mnt_inv_q;
    end else if (fill_last) begin
      tu_en  = 1'b1;
      tu_idx = fill_line_q[IDX_W-1:0];
      tu_tag = fill_line_q[LINE_W-1:IDX_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      word_q      <= '0;
      wb_line_q   <= '0;
      fill_line_q <= '0;
      wb_mnt_q    <= 1'b0;
      mnt_inv_q   <= 1'b0;
      dma_we_q    <= 1'b0;
      dma_addr_q  <= '0;
      dma_wdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (g_dma) begin
            dma_addr_q  <= dma_addr_i;
            dma_we_q    <= dma_we_i;
            dma_wdata_q <= dma_wdata_i;
            if (dma_we_i || !lk_hit) st_q <= ST_DMA;
          end else if (mnt_wb_go) begin
            wb_line_q <= {sel_tag, sel_idx};
            wb_mnt_q  <= 1'b1;
            mnt_inv_q <= mnt_op_i[1];
            word_q    <= '0;
            st_q      <= ST_WB;
          end else if (g_cpu && !lk_hit) begin
            fill_line_q <= {sel_tag, sel_idx};
            word_q      <= '0;
            if (lk_dirty) begin
              wb_line_q <= {lk_tag, sel_idx};
              wb_mnt_q  <= 1'b0;
              st_q      <= ST_WB;
            end else begin
              st_q <= ST_FILL;
            end
          end
        end
        ST_WB: if (mem_ready_i) begin
          word_q <= word_q + OFF_W'(1);
          if (word_q == LAST_OFF) begin
            word_q <= '0;
            st_q   <= wb_mnt_q ? ST_IDLE : ST_FILL;
          end
        end
        ST_FILL: if (mem_ready_i) begin
          word_q <= word_q + OFF_W'(1);
          if (word_q == LAST_OFF) begin
            word_q <= '0;
            st_q   <= ST_IDLE;
          end
        end
        default: if (mem_ready_i) st_q <= ST_IDLE;
      endcase
    end
  end

  a_r5_snoop_before_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && dma_req_i && cpu_req_i) |-> !cpu_ready_o);
  a_r6_read_hit_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && dma_req_i && !dma_we_i && dma_ready_o) |=> !mem_req_o);
  a_r7_write_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && dma_req_i && dma_we_i) |=>
      (mem_req_o && mem_we_o && mem_addr_o == $past(dma_addr_i)));
  a_r12_quick_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && mnt_req_i && !dma_req_i && mnt_done_o) |=> !mem_req_o);
  a_r13_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

// File: tb/snoop_wb_cache_bench.sv
`timescale 1ns/1ps
module snoop_wb_cache_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready_o;
  logic [31:0] cpu_rdata_o;
  logic        dma_req = 1'b0, dma_we = 1'b0;
  logic [11:0] dma_addr = '0;
  logic [31:0] dma_wdata = '0;
  logic        dma_ready_o;
  logic [31:0] dma_rdata_o;
  logic        mnt_req = 1'b0;
  logic [1:0]  mnt_op = '0;
  logic [11:0] mnt_addr = '0;
  logic        mnt_done_o;
  logic        mem_req_o, mem_we_o;
  logic [11:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_ready_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int mem[4096];
  int m_mem[4096];
  int shadow[4096];
  bit mv[16];
  bit md[16];
  int mt[16];
  int act_log[$];
  int exp_log[$];
  int checks = 0, errors = 0, stab_err = 0;

  always #10 clk = ~clk;

  snoop_wb_cache u_snoop_wb_cache (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
    .dma_req_i(dma_req), .dma_we_i(dma_we), .dma_addr_i(dma_addr), .dma_wdata_i(dma_wdata),
    .dma_ready_o(dma_ready_o), .dma_rdata_o(dma_rdata_o),
    .mnt_req_i(mnt_req), .mnt_op_i(mnt_op), .mnt_addr_i(mnt_addr), .mnt_done_o(mnt_done_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  // memory model: acknowledge on the second cycle of each request
  initial begin
    int cnt = 0;
    bit p_req = 1'b0, p_rdy = 1'b0, p_we = 1'b0;
    int p_addr = 0;
    forever begin
      @(negedge clk);
      if (!rst_ni) begin
        mem_ready_i = 1'b0;
        cnt = 0;
      end else begin
        if (p_req && !p_rdy && mem_req_o &&
            (int'(mem_addr_o) != p_addr || mem_we_o != p_we)) stab_err++;
        if (mem_ready_i) begin
          mem_ready_i = 1'b0;
          cnt = 0;
        end else if (mem_req_o) begin
          if (cnt == 1) begin
            mem_ready_i = 1'b1;
            act_log.push_back((int'(mem_we_o) << 16) | int'(mem_addr_o));
            if (mem_we_o) mem[int'(mem_addr_o)] = int'(mem_wdata_o);
            else mem_rdata_i = 32'(mem[int'(mem_addr_o)]);
            cnt = 0;
          end else cnt++;
        end else cnt = 0;
        p_req = mem_req_o;
        p_rdy = mem_ready_i;
        p_we = mem_we_o;
        p_addr = int'(mem_addr_o);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic log_chk(input string rq);
    bit ok = (act_log.size() == exp_log.size());
    int bad = 0;
    if (ok) begin
      foreach (exp_log[i]) if (act_log[i] != exp_log[i]) begin
        ok = 1'b0;
        bad = i;
        break;
      end
    end
    if (!ok && act_log.size() == exp_log.size())
      chk(ok, rq, "memory access", act_log[bad], exp_log[bad]);
    else
      chk(ok, rq, "memory access count", act_log.size(), exp_log.size());
  endtask

  function automatic bit rdy(input int port);
    return port == 0 ? cpu_ready_o : (port == 1 ? dma_ready_o : mnt_done_o);
  endfunction

  task automatic xact(input int port, input int we_op, input int addr, input int wd,
                      output int rd, output int waits);
    @(negedge clk);
    act_log.delete();
    if (port == 0) begin
      cpu_req = 1'b1; cpu_we = we_op[0]; cpu_addr = 12'(addr); cpu_wdata = 32'(wd);
    end else if (port == 1) begin
      dma_req = 1'b1; dma_we = we_op[0]; dma_addr = 12'(addr); dma_wdata = 32'(wd);
    end else begin
      mnt_req = 1'b1; mnt_op = 2'(we_op); mnt_addr = 12'(addr);
    end
    waits = 0;
    #5;
    while (!rdy(port) && waits < 1000) begin
      @(negedge clk);
      #5;
      waits++;
    end
    rd = (port == 1) ? int'(dma_rdata_o) : int'(cpu_rdata_o);
    @(posedge clk);
    #1;
    cpu_req = 1'b0; dma_req = 1'b0; mnt_req = 1'b0;
  endtask

  task automatic do_cpu(input bit we, input int addr, input int wd, input string rq);
    int idx = (addr >> 2) & 15, tg = addr >> 6, rd, w;
    bit hit = mv[idx] && mt[idx] == tg;
    exp_log.delete();
    if (!hit) begin
      if (mv[idx] && md[idx]) begin
        int vb = (mt[idx] << 6) | (idx << 2);
        for (int k = 0; k < 4; k++) begin
          exp_log.push_back((1 << 16) | (vb + k));
          m_mem[vb + k] = shadow[vb + k];
        end
      end
      for (int k = 0; k < 4; k++) exp_log.push_back((addr & ~3) + k);
      mv[idx] = 1'b1; mt[idx] = tg; md[idx] = 1'b0;
    end
    if (we) begin
      shadow[addr] = wd;
      md[idx] = 1'b1;
    end
    xact(0, int'(we), addr, wd, rd, w);
    log_chk(rq);
    if (!we) chk(rd == shadow[addr], rq, "cpu read data", rd, shadow[addr]);
    if (hit) chk(w == 0, rq, "cpu hit latency", w, 0);
  endtask

  task automatic do_dma(input bit we, input int addr, input int wd, input string rq);
    int idx = (addr >> 2) & 15, tg = addr >> 6, rd, w;
    bit hit = mv[idx] && mt[idx] == tg;
    exp_log.delete();
    if (we) begin
      exp_log.push_back((1 << 16) | addr);
      shadow[addr] = wd;
      m_mem[addr] = wd;
    end else if (!hit) exp_log.push_back(addr);
    xact(1, int'(we), addr, wd, rd, w);
    log_chk(rq);
    if (!we) chk(rd == shadow[addr], rq, "dma read data", rd, shadow[addr]);
    if (hit && !we) chk(w == 0, rq, "dma hit latency", w, 0);
  endtask

  task automatic do_mnt(input int op, input int addr, input string rq);
    int idx = (addr >> 2) & 15, tg = addr >> 6, base = addr & ~3, rd, w;
    bit hit = mv[idx] && mt[idx] == tg;
    exp_log.delete();
    if (hit && md[idx] && op[0]) begin
      for (int k = 0; k < 4; k++) begin
        exp_log.push_back((1 << 16) | (base + k));
        m_mem[base + k] = shadow[base + k];
      end
      md[idx] = 1'b0;
    end
    if (hit && op[1]) begin
      mv[idx] = 1'b0;
      md[idx] = 1'b0;
      for (int k = 0; k < 4; k++) shadow[base + k] = m_mem[base + k];
    end
    xact(2, op, addr, 0, rd, w);
    log_chk(rq);
    if (exp_log.size() == 0) chk(w == 0, rq, "command latency", w, 0);
  endtask

  initial begin
    int r;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 32'h1000_0000 + i * 7;
      m_mem[i] = mem[i];
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #5;
    chk(!cpu_ready_o && !dma_ready_o && !mnt_done_o && !mem_req_o, "R1", "idle outputs after reset",
        int'({cpu_ready_o, dma_ready_o, mnt_done_o, mem_req_o}), 0);

    do_cpu(1'b0, 12'h010, 0, "R1");                 // cold miss fills line
    do_cpu(1'b0, 12'h012, 0, "R2");                 // read hit
    do_cpu(1'b1, 12'h011, 32'h0000_A5A5, "R2");     // write hit, cache only
    do_cpu(1'b0, 12'h011, 0, "R2");
    do_dma(1'b0, 12'h011, 0, "R6");                 // dma read hit on dirty word
    chk(mem[12'h011] == m_mem[12'h011], "R6", "memory untouched", mem[12'h011], m_mem[12'h011]);
    do_dma(1'b1, 12'h013, 32'h0000_BEEF, "R7");     // dma write hit
    chk(mem[12'h013] == 32'h0000_BEEF, "R7", "memory copy", mem[12'h013], 32'h0000_BEEF);
    do_cpu(1'b0, 12'h013, 0, "R7");                 // cached copy updated
    do_dma(1'b0, 12'h200, 0, "R8");                 // dma read miss
    do_dma(1'b1, 12'h204, 32'h0000_0B0B, "R8");     // dma write miss
    do_cpu(1'b0, 12'h204, 0, "R8");                 // still a miss: no allocation
    do_cpu(1'b0, 12'h050, 0, "R3");                 // dirty victim written back first
    chk(mem[12'h011] == 32'h0000_A5A5, "R3", "victim word in memory", mem[12'h011], 32'h0000_A5A5);
    do_cpu(1'b1, 12'h051, 32'h0000_1111, "R2");
    do_mnt(1, 12'h051, "R9");                       // write back dirty line
    chk(mem[12'h051] == 32'h0000_1111, "R9", "written word", mem[12'h051], 32'h0000_1111);
    do_mnt(1, 12'h051, "R12");                      // now clean: quick done
    do_cpu(1'b0, 12'h051, 0, "R9");                 // still valid: hit
    do_cpu(1'b1, 12'h052, 32'h0000_2222, "R2");
    do_mnt(2, 12'h052, "R10");                      // invalidate dirty line
    do_mnt(1, 12'h052, "R4");                       // no dirty leftover
    do_cpu(1'b0, 12'h052, 0, "R10");                // refill returns memory data
    do_cpu(1'b1, 12'h053, 32'h0000_3333, "R2");
    do_mnt(3, 12'h053, "R11");
    do_cpu(1'b0, 12'h053, 0, "R11");
    do_mnt(3, 12'h300, "R12");                      // absent line
    do_mnt(2, 12'h301, "R12");

    // R5: DMA and CPU in the same cycle, both hits
    @(negedge clk);
    act_log.delete();
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 12'h204;
    dma_req = 1'b1; dma_we = 1'b0; dma_addr = 12'h205;
    #5;
    chk(dma_ready_o && !cpu_ready_o, "R5", "dma served first", int'({dma_ready_o, cpu_ready_o}), 2);
    r = int'(dma_rdata_o);
    chk(r == shadow[12'h205], "R6", "dma data under contention", r, shadow[12'h205]);
    @(posedge clk);
    #1;
    dma_req = 1'b0;
    @(negedge clk);
    #5;
    chk(cpu_ready_o, "R5", "cpu served after dma", int'(cpu_ready_o), 1);
    r = int'(cpu_rdata_o);
    chk(r == shadow[12'h204], "R5", "cpu data after dma", r, shadow[12'h204]);
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
    chk(act_log.size() == 0, "R5", "no memory traffic", act_log.size(), 0);

    chk(stab_err == 0, "R13", "request held while waiting", stab_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule